// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register Bank

This block holds one software interrupt request per hart and drives each hart's software interrupt line from it. Software reaches it over a simple 32-bit register bus with a select, a write strobe, a byte address and write data. Read data is registered and appears one cycle after the read request. The word for hart `i` sits at byte offset `4*i`, and only bit 0 of each word carries meaning.

A build-time parameter picks one of two behaviours. In level mode, each word is an ordinary read/write pending bit that holds the interrupt line high until software clears it. In trigger mode, a word only acts as a set request. Writing 1 to bit 0 sends a single-cycle pulse on that hart's line to the core, which keeps and clears its own pending state. Reads return zero in trigger mode.

Top module: `swi_bank`

## Requirements
- R1: Synchronous active-high reset drives every interrupt line low and the read data to zero. In level mode, reset also clears every pending bit, so they read back as 0 afterwards.
- R2: In level mode, a write with bit 0 = 1 to the word at byte offset 4*i raises hart i's line in the cycle after the write. Bits 31..1 of the write data are ignored.
- R3: In level mode, a write with bit 0 = 0 to offset 4*i lowers hart i's line in the cycle after the write, whatever bits 31..1 hold.
- R4: A read request (select high, write low) loads the read data register, which is visible in the following cycle. In level mode it holds the addressed pending bit in bit 0, with bits 31..1 zero. In any cycle without a read request, the read data returns to zero one cycle later.
- R5: In trigger mode, a write with bit 0 = 1 to offset 4*i drives hart i's line high for exactly the one cycle that follows the write.
- R6: In trigger mode, a write with bit 0 = 0 leaves every line low.
- R7: In trigger mode, every read returns zero.
- R8: An access is decoded only if the address has bits 1..0 equal to zero and lies below 4*NUM_HARTS. Any other write changes no line, and any other read returns zero.
- R9: Writes to different words in successive cycles each change only the hart they address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_rdata | output | 32 | Registered read data |
| sw_irq | output | NUM_HARTS | Software interrupt line per hart |

## Verification
The bench drives one level-mode instance and one trigger-mode instance from the same bus, and checks both every cycle against a behavioural model.

The stimulus covers these corner cases:
- Writes with bit 0 clear and every other data bit set. A design that decodes the whole word would set or keep the line.
- An address exactly at 4*NUM_HARTS, a misaligned address, and the top of the address space. A decoder that drops the low bits or aliases the index would hit a real hart.
- Back-to-back writes to different harts. A design with a stale or shared write index would disturb the wrong line.
- In trigger mode, writes of 0. A stretched pulse or a level latch would show up as a line held high into the second cycle.
- A reset taken while bits are set, so a missing clear is seen on the lines.

// File: rtl/swi_pkg.sv
package swi_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_LEVEL   = 1'b0,
        MODE_TRIGGER = 1'b1
    } swi_mode_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic bit_val;
    } bus_op_t;

    function automatic word_t bit_to_word(input logic b);
        word_t w;
        w    = '0;
        w[0] = b;
        return w;
    endfunction

endpackage

// File: rtl/swi_addr_dec.sv
module swi_addr_dec #(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [NUM_HARTS-1:0] sel_oh
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar k = 0; k < NUM_HARTS; k++) begin : g_match
        assign sel_oh[k] = aligned && (widx == WIDX_W'(k));
    end

    assign hit = |sel_oh;
endmodule

// File: rtl/swi_cell.sv
module swi_cell #(
    parameter swi_pkg::swi_mode_e MODE = swi_pkg::MODE_LEVEL
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_bit,
    output logic line,
    output logic rd_bit
);
    if (MODE == swi_pkg::MODE_LEVEL) begin : g_level
        logic pend_q;
        always_ff @(posedge clk) begin
            if (rst)        pend_q <= 1'b0;
            else if (wr_en) pend_q <= wr_bit;
        end
        assign line   = pend_q;
        assign rd_bit = pend_q;
    end else begin : g_trigger
        logic pulse_q;
        always_ff @(posedge clk) begin
            if (rst) pulse_q <= 1'b0;
            else     pulse_q <= wr_en & wr_bit;
        end
        assign line   = pulse_q;
        assign rd_bit = 1'b0;
    end
endmodule

// File: rtl/swi_bank.sv
module swi_bank #(
    parameter int NUM_HARTS    = 4,
    parameter int ADDR_W       = 12,
    parameter bit TRIGGER_MODE = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic [NUM_HARTS-1:0]  sw_irq
);
    import swi_pkg::*;

    localparam swi_mode_e MODE = TRIGGER_MODE ? MODE_TRIGGER : MODE_LEVEL;

    logic                 hit;
    logic [NUM_HARTS-1:0] sel_oh;
    logic [NUM_HARTS-1:0] rd_bits;
    bus_op_t              op;
    word_t                rdata_q;
    logic                 unused_wdata;

    assign unused_wdata = ^bus_wdata[31:1];

    swi_addr_dec #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .addr   (bus_addr),
        .hit    (hit),
        .sel_oh (sel_oh)
    );

    always_comb begin
        op.rd      = bus_sel & ~bus_we;
        op.wr      = bus_sel & bus_we & hit;
        op.bit_val = bus_wdata[0];
    end

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        swi_cell #(
            .MODE (MODE)
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (op.wr & sel_oh[h]),
            .wr_bit (op.bit_val),
            .line   (sw_irq[h]),
            .rd_bit (rd_bits[h])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (op.rd) rdata_q <= bit_to_word(|(sel_oh & rd_bits));
        else            rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/swi_bank_chk.sv
module swi_bank_chk #(
    parameter int NUM_HARTS    = 4,
    parameter int ADDR_W       = 12,
    parameter bit TRIGGER_MODE = 1'b0
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_HARTS-1:0] sw_irq
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0]    widx;
    logic [NUM_HARTS-1:0] wr_oh;
    logic                 in_rng;
    logic                 wr_any;
    logic                 unused_hi;

    assign unused_hi = ^bus_wdata[31:1];
    assign widx      = bus_addr[ADDR_W-1:2];
    always_comb begin
        for (int k = 0; k < NUM_HARTS; k++)
            wr_oh[k] = (bus_addr[1:0] == 2'b00) && (widx == WIDX_W'(k));
    end
    assign in_rng = |wr_oh;
    assign wr_any = bus_sel && bus_we && in_rng;

    // R1
    p_reset_low_r1: assert property (@(posedge clk) rst |=> (sw_irq == '0) && (bus_rdata == '0));

    // R4
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst) bus_rdata[31:1] == 31'd0);

    if (TRIGGER_MODE) begin : g_trig
        p_one_line_r5: assert property (@(posedge clk) disable iff (rst) $onehot0(sw_irq));
        p_pulse_src_r5: assert property (@(posedge clk) disable iff (rst)
            (sw_irq != '0) |-> $past(wr_any && bus_wdata[0]));
        p_pulse_hit_r5: assert property (@(posedge clk) disable iff (rst)
            (wr_any && bus_wdata[0]) |=> (sw_irq == $past(wr_oh)));
        p_zero_write_r6: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && bus_we && !bus_wdata[0]) |=> (sw_irq == '0));
        p_read_zero_r7: assert property (@(posedge clk) disable iff (rst) bus_rdata == '0);
    end else begin : g_level
        p_write_r2: assert property (@(posedge clk) disable iff (rst)
            wr_any |=> ((sw_irq & $past(wr_oh)) == ($past(bus_wdata[0]) ? $past(wr_oh) : '0)));
        p_others_r9: assert property (@(posedge clk) disable iff (rst)
            wr_any |=> ((sw_irq & ~$past(wr_oh)) == ($past(sw_irq) & ~$past(wr_oh))));
        p_ignored_r8: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && !in_rng) |=> $stable(sw_irq));
        p_oob_read_r8: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && !bus_we && !in_rng) |=> (bus_rdata == '0));
    end
endmodule

bind swi_bank swi_bank_chk #(
    .NUM_HARTS    (NUM_HARTS),
    .ADDR_W       (ADDR_W),
    .TRIGGER_MODE (TRIGGER_MODE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sw_irq    (sw_irq)
);

// File: tb/sim_swi_bank.sv
`timescale 1ns/1ps
module sim_swi_bank;
    localparam int N  = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0;
    logic          we  = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rd0, rd1;
    logic [N-1:0]  irq0, irq1;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";
    bit    started  = 1'b0;
    bit    done     = 1'b0;

    // reference model state
    logic [N-1:0] m_pend = '0;
    logic [N-1:0] s_pulse = '0;
    logic [31:0]  m_rd = '0;
    logic [31:0]  s_rd = '0;

    always #2 clk = ~clk;

    swi_bank #(.NUM_HARTS(N), .ADDR_W(AW), .TRIGGER_MODE(1'b0)) u0 (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd0), .sw_irq(irq0));

    swi_bank #(.NUM_HARTS(N), .ADDR_W(AW), .TRIGGER_MODE(1'b1)) u1 (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd1), .sw_irq(irq1));

    always @(posedge clk) begin
        int  idx;
        bit  inr;
        idx = int'(addr) / 4;
        inr = (addr % 4 == 0) && (idx < N);
        if (rst) begin
            m_pend  = '0;
            s_pulse = '0;
            m_rd    = '0;
            s_rd    = '0;
        end else begin
            m_rd    = '0;
            s_rd    = '0;
            if (sel && !we && inr) m_rd = {31'd0, m_pend[idx]};
            s_pulse = '0;
            if (sel && we && inr) begin
                m_pend[idx] = wdata[0];
                if (wdata[0]) s_pulse[idx] = 1'b1;
            end
        end
        started = 1'b1;
    end

    task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            chk(tag, "level irq", 32'(irq0), 32'(m_pend));
            chk(tag, "level rdata", rd0, m_rd);
            chk(tag, "trigger irq", 32'(irq1), 32'(s_pulse));
            chk(tag, "trigger rdata", rd1, s_rd);
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        sel = 1'b1; we = 1'b0; addr = a; wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        idle(2);
        rst = 1'b0;
        tag = "R1";
        idle(2);
        rd(0); idle(1);

        tag = "R2";
        wr(12'h008, 32'h0000_0001);
        wr(12'h004, 32'hFFFF_FFFF);
        idle(2);

        tag = "R4";
        for (int h = 0; h < N; h++) rd(AW'(4 * h));
        idle(2);

        tag = "R3";
        wr(12'h008, 32'hFFFF_FFFE);
        idle(1);
        rd(12'h008); rd(12'h004);
        idle(1);

        tag = "R9";
        wr(12'h000, 32'h1);
        wr(12'h00C, 32'h1);
        wr(12'h000, 32'h0);
        wr(12'h004, 32'h0);
        idle(1);
        for (int h = 0; h < N; h++) rd(AW'(4 * h));

        tag = "R8";
        wr(AW'(4 * N), 32'h1);
        wr(12'h005, 32'h1);
        wr(12'h00E, 32'h1);
        wr(12'hFFC, 32'h1);
        wr(12'h00D, 32'h0);
        rd(AW'(4 * N)); rd(12'h00D); rd(12'hFFC);
        idle(2);

        tag = "R5";
        wr(12'h000, 32'h1);
        idle(1);
        wr(12'h004, 32'h1);
        wr(12'h008, 32'h1);
        wr(12'h004, 32'h1);
        idle(2);

        tag = "R6";
        wr(12'h000, 32'h0);
        wr(12'h008, 32'hFFFF_FFFE);
        idle(2);

        tag = "R7";
        for (int h = 0; h < N; h++) rd(AW'(4 * h));
        idle(2);

        tag = "R1";
        wr(12'h004, 32'h1);
        wr(12'h00C, 32'h1);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        for (int h = 0; h < N; h++) rd(AW'(4 * h));
        idle(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule